// File: doc/BRIEF.md
# Pipelined Single-Precision Reciprocal Unit

This block returns an approximation of 1/x for an IEEE-754 single-precision operand. The fraction field is split into two parts. The top `SEG_BITS` bits (default 7, giving 128 segments of [1,2)) select a row of three coefficient tables. The remaining 16 bits form an unsigned offset t. Within each segment the reciprocal of the significand is modelled by a quadratic, and the quadratic is evaluated in nested form `(c2*t + c1)*t + c0`. Two signed multiply-add steps do this work, each split over two register stages. The result exponent is reflected around the bias. After the evaluation a rounding and renormalisation stage runs, and a final stage merges in the special operands.

The pipeline has no stalls and no back-pressure. One operand may enter on every clock, and each result appears exactly eight clocks after its operand, in the same order. Class and sign information runs beside the arithmetic path through a delay line of matched length. The unit is meant to feed a pipelined multiplier, which turns `a * (1/b)` into a divider with a throughput of one quotient per clock. The coefficient tables are ROM arrays with a registered read. An initial block computes them by fitting a quadratic through the start, middle and end point of each segment.

Top module: `recip_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow, by eight rising clock edges, a cycle with `in_valid` high. The unit accepts an operand on every cycle, back to back, and returns the results in the order the operands entered.
- R2: `rst_n` is an asynchronous reset, active low. While it is low, `out_valid` is low. Operands still in flight when reset is asserted never produce an output.
- R3: An operand with biased exponent field e (bits 30:23) in 1..253 and a zero fraction field (bits 22:0) gives the exact result: sign unchanged, exponent field 254−e, fraction zero.
- R4: An operand with e in 1..252 and a nonzero fraction gives a result with the same sign (bit 31) and an exponent field of 253−e or 254−e. The result differs from the true reciprocal by at most one unit in the last place of the result.
- R5: An operand with exponent field 0 (a zero or a subnormal) gives infinity with the operand's sign: `{sign, 8'hFF, 23'h0}`.
- R6: An operand with exponent field 255 and a zero fraction (an infinity) gives zero with the operand's sign: `{sign, 31'h0}`.
- R7: An operand with exponent field 255 and a nonzero fraction (any NaN, of either sign, quiet or signalling) gives the quiet NaN `32'h7FC00000`.
- R8: When the true result lies below the normal range, the result is flushed to zero with the operand's sign, `{sign, 31'h0}`. This covers e = 254 with any fraction, and e = 253 with a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand qualifier, one operand per cycle |
| in_data | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result qualifier, eight cycles after its operand |
| out_data | output | 32 | Single-precision reciprocal |

## Verification
A corrupt coefficient row stays hidden for most operands. It shows up only as an error of more than one ulp, and only for operands whose top fraction bits select that row, eight cycles after they enter. For this reason the stimulus sweeps both ends of every segment. A side-band delay that is one stage too short or too long pairs a class or exponent with the neighbouring operand's significand. In a back-to-back stream this shows up immediately, as a wrong exponent or a special value on the wrong result. A fault in the valid chain changes the cycle in which a result arrives, and the arrival cycle is compared against the cycle in which each operand entered.

// File: rtl/recip_pkg.sv
package recip_pkg;

    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int EXP_BIAS = 127;

    localparam logic [FP_W-1:0] QUIET_NAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_e;

    typedef struct packed {
        logic             valid;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic             pow2;
        fp_class_e        cls;
    } fp_meta_t;

endpackage

// File: rtl/recip_pipe_delay.sv
module recip_pipe_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] taps [DEPTH+1];

    assign taps[0] = d;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                taps[g+1] <= '0;
            end else begin
                taps[g+1] <= taps[g];
            end
        end
    end

    assign q = taps[DEPTH];

endmodule

// File: rtl/recip_coef_rom.sv
module recip_coef_rom #(
    parameter int SEG_BITS  = 7,
    parameter int OFF_W     = 16,
    parameter int COEF_FRAC = 30,
    parameter int COEF_W    = 32
) (
    input  logic                     clk,
    input  logic [SEG_BITS-1:0]      idx,
    input  logic [OFF_W-1:0]         off_in,
    output logic signed [COEF_W-1:0] c0,
    output logic signed [COEF_W-1:0] c1,
    output logic signed [COEF_W-1:0] c2,
    output logic [OFF_W-1:0]         off_out
);

    localparam int  SEGS  = 2 ** SEG_BITS;
    localparam real SCALE = 2.0 ** COEF_FRAC;

    logic signed [COEF_W-1:0] tab_c0 [SEGS];
    logic signed [COEF_W-1:0] tab_c1 [SEGS];
    logic signed [COEF_W-1:0] tab_c2 [SEGS];

    function automatic logic signed [COEF_W-1:0] to_fix(input real v);
        real s;
        s = v * SCALE;
        if (s >= 0.0) begin
            return COEF_W'($rtoi(s + 0.5));
        end
        return -COEF_W'($rtoi(0.5 - s));
    endfunction

    // Quadratic through t = 0, 1/2, 1 of y(t) = 1 / (base + t * width)
    initial begin
        for (int i = 0; i < SEGS; i++) begin
            real width, base, y_lo, y_mid, y_hi;
            width = 1.0 / real'(SEGS);
            base  = 1.0 + real'(i) * width;
            y_lo  = 1.0 / base;
            y_mid = 1.0 / (base + 0.5 * width);
            y_hi  = 1.0 / (base + width);
            tab_c0[i] = to_fix(y_lo);
            tab_c1[i] = to_fix(4.0 * y_mid - 3.0 * y_lo - y_hi);
            tab_c2[i] = to_fix(2.0 * y_lo - 4.0 * y_mid + 2.0 * y_hi);
        end
    end

    always_ff @(posedge clk) begin
        c0      <= tab_c0[idx];
        c1      <= tab_c1[idx];
        c2      <= tab_c2[idx];
        off_out <= off_in;
    end

endmodule

// File: rtl/recip_horner.sv
module recip_horner #(
    parameter int OFF_W  = 16,
    parameter int COEF_W = 32
) (
    input  logic                     clk,
    input  logic signed [COEF_W-1:0] c0,
    input  logic signed [COEF_W-1:0] c1,
    input  logic signed [COEF_W-1:0] c2,
    input  logic [OFF_W-1:0]         off,
    output logic signed [COEF_W-1:0] poly
);

    localparam int PROD_W = COEF_W + OFF_W + 1;

    logic signed [PROD_W-1:0] prod_a, prod_b;
    logic signed [COEF_W-1:0] c1_a, c0_a, c0_b, c0_c, acc_b;
    logic [OFF_W-1:0]         off_a, off_b;

    // stage 3: c2 * t
    always_ff @(posedge clk) begin
        prod_a <= c2 * $signed({1'b0, off});
        c1_a   <= c1;
        c0_a   <= c0;
        off_a  <= off;
    end

    // stage 4: + c1
    always_ff @(posedge clk) begin
        acc_b <= COEF_W'(prod_a >>> OFF_W) + c1_a;
        c0_b  <= c0_a;
        off_b <= off_a;
    end

    // stage 5: (c2*t + c1) * t
    always_ff @(posedge clk) begin
        prod_b <= acc_b * $signed({1'b0, off_b});
        c0_c   <= c0_b;
    end

    // stage 6: + c0
    always_ff @(posedge clk) begin
        poly <= COEF_W'(prod_b >>> OFF_W) + c0_c;
    end

endmodule

// File: rtl/recip_unit.sv
module recip_unit
    import recip_pkg::*;
#(
    parameter int SEG_BITS  = 7,
    parameter int COEF_FRAC = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [FP_W-1:0] in_data,
    output logic            out_valid,
    output logic [FP_W-1:0] out_data
);

    localparam int OFF_W    = FRAC_W - SEG_BITS;
    localparam int COEF_W   = COEF_FRAC + 2;
    localparam int META_W   = $bits(fp_meta_t);
    localparam int META_DLY = 5;    // table read plus four evaluation stages
    localparam logic [EXP_W-1:0] EXP_ONES  = '1;
    localparam logic [EXP_W-1:0] EXP_EXACT = EXP_W'(2 * EXP_BIAS);
    localparam logic [EXP_W-1:0] EXP_GEN   = EXP_W'(2 * EXP_BIAS - 1);
    localparam logic signed [COEF_W-1:0] UNITY =
        {{(COEF_W - COEF_FRAC - 1){1'b0}}, 1'b1, {COEF_FRAC{1'b0}}};

    // ---------------- stage 1: decode ----------------
    fp_meta_t            in_meta, s1_meta, s6_meta;
    logic [SEG_BITS-1:0] s1_idx;
    logic [OFF_W-1:0]    s1_off, s2_off;
    logic [FRAC_W-1:0]   in_frac;

    assign in_frac = in_data[FRAC_W-1:0];

    always_comb begin
        in_meta.valid = in_valid;
        in_meta.sign  = in_data[FP_W-1];
        in_meta.exp   = in_data[FP_W-2 -: EXP_W];
        in_meta.pow2  = (in_frac == '0);
        if (in_meta.exp == '0) begin
            in_meta.cls = CLS_ZERO;
        end else if (in_meta.exp == EXP_ONES) begin
            in_meta.cls = (in_frac == '0) ? CLS_INF : CLS_NAN;
        end else begin
            in_meta.cls = CLS_NORM;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_meta <= '0;
        end else begin
            s1_meta <= in_meta;
        end
    end

    always_ff @(posedge clk) begin
        s1_idx <= in_frac[FRAC_W-1 -: SEG_BITS];
        s1_off <= in_frac[OFF_W-1:0];
    end

    // ---------------- stages 2..6: table and polynomial ----------------
    logic signed [COEF_W-1:0] s2_c0, s2_c1, s2_c2, s6_poly;

    recip_coef_rom #(
        .SEG_BITS (SEG_BITS),
        .OFF_W    (OFF_W),
        .COEF_FRAC(COEF_FRAC),
        .COEF_W   (COEF_W)
    ) i_rom (
        .clk    (clk),
        .idx    (s1_idx),
        .off_in (s1_off),
        .c0     (s2_c0),
        .c1     (s2_c1),
        .c2     (s2_c2),
        .off_out(s2_off)
    );

    recip_horner #(
        .OFF_W (OFF_W),
        .COEF_W(COEF_W)
    ) i_horner (
        .clk (clk),
        .c0  (s2_c0),
        .c1  (s2_c1),
        .c2  (s2_c2),
        .off (s2_off),
        .poly(s6_poly)
    );

    logic [META_W-1:0] meta_q;

    recip_pipe_delay #(
        .W    (META_W),
        .DEPTH(META_DLY)
    ) i_meta_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (s1_meta),
        .q    (meta_q)
    );

    assign s6_meta = fp_meta_t'(meta_q);

    // ---------------- stage 7: round and renormalise ----------------
    logic                      at_one, carry;
    logic [FRAC_W:0]           rnd;
    logic [FRAC_W-1:0]         mant_n;
    logic signed [EXP_W+1:0]   exp_n;

    always_comb begin
        at_one = s6_meta.pow2 || (s6_poly >= UNITY);
        rnd    = {1'b0, s6_poly[COEF_FRAC-2 -: FRAC_W]}
               + {{FRAC_W{1'b0}}, s6_poly[COEF_FRAC-FRAC_W-2]};
        carry  = !at_one && rnd[FRAC_W];
        mant_n = (at_one || carry) ? '0 : rnd[FRAC_W-1:0];
        exp_n  = $signed({2'b00, (at_one ? EXP_EXACT : EXP_GEN)})
               - $signed({2'b00, s6_meta.exp})
               + $signed({{(EXP_W+1){1'b0}}, carry});
    end

    logic                    s7_valid, s7_sign;
    fp_class_e               s7_cls;
    logic signed [EXP_W+1:0] s7_exp;
    logic [FRAC_W-1:0]       s7_mant;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s7_valid <= 1'b0;
        end else begin
            s7_valid <= s6_meta.valid;
        end
    end

    always_ff @(posedge clk) begin
        s7_sign <= s6_meta.sign;
        s7_cls  <= s6_meta.cls;
        s7_exp  <= exp_n;
        s7_mant <= mant_n;
    end

    // ---------------- stage 8: special-value merge ----------------
    logic [FP_W-1:0] result;

    always_comb begin
        unique case (s7_cls)
            CLS_NAN:  result = QUIET_NAN;
            CLS_ZERO: result = {s7_sign, EXP_ONES, {FRAC_W{1'b0}}};
            CLS_INF:  result = {s7_sign, {(FP_W-1){1'b0}}};
            default: begin
                if (s7_exp <= 0) begin
                    result = {s7_sign, {(FP_W-1){1'b0}}};
                end else begin
                    result = {s7_sign, s7_exp[EXP_W-1:0], s7_mant};
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s7_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_data <= result;
    end

endmodule

// File: rtl/recip_unit_chk.sv
module recip_unit_chk #(
    parameter int LAT = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic [31:0] out_data
);

    logic [LAT-1:0] vq;
    logic [31:0]    dq [LAT];
    logic           o_vld;
    logic [31:0]    o_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vq <= '0;
        end else begin
            vq <= {vq[LAT-2:0], in_valid};
        end
    end

    always_ff @(posedge clk) begin
        dq[0] <= in_data;
        for (int k = 1; k < LAT; k++) begin
            dq[k] <= dq[k-1];
        end
    end

    assign o_vld = vq[LAT-1];
    assign o_op  = dq[LAT-1];

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == o_vld);

    // R3
    pow2_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_op[22:0] == 23'd0 && o_op[30:23] != 8'd0 && o_op[30:23] <= 8'd253)
        |-> out_data == {o_op[31], 8'(8'd254 - o_op[30:23]), 23'd0});

    // R5
    zero_to_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_op[30:23] == 8'd0) |-> out_data == {o_op[31], 8'hFF, 23'd0});

    // R6
    inf_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_op[30:23] == 8'hFF && o_op[22:0] == 23'd0) |-> out_data == {o_op[31], 31'd0});

    // R7
    nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_op[30:23] == 8'hFF && o_op[22:0] != 23'd0) |-> out_data == 32'h7FC0_0000);

    // R8
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && o_op[30:23] == 8'd254) |-> out_data == {o_op[31], 31'd0});

endmodule

bind recip_unit recip_unit_chk #(.LAT(8)) i_recip_unit_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/test_recip_unit.sv
`timescale 1ns/1ps
module test_recip_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_data;
    logic        out_valid;
    logic [31:0] out_data;

    int n_checks = 0;
    int n_errors = 0;
    int cyc      = 0;
    int n_sent   = 0;
    int n_recv   = 0;

    logic [31:0] q_in    [1024];
    logic [31:0] q_exp   [1024];
    bit          q_exact [1024];
    int          q_cyc   [1024];
    string       q_req   [1024];

    recip_unit i_recip_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_data (out_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // {requirement number, operand, expected result}
    localparam int NVEC = 18;
    localparam logic [71:0] VEC [NVEC] = '{
        {8'd3, 32'h3F80_0000, 32'h3F80_0000},
        {8'd3, 32'h4000_0000, 32'h3F00_0000},
        {8'd3, 32'h3F00_0000, 32'h4000_0000},
        {8'd3, 32'hC100_0000, 32'hBE00_0000},
        {8'd3, 32'h7E80_0000, 32'h0080_0000},
        {8'd3, 32'h0080_0000, 32'h7E80_0000},
        {8'd5, 32'h0000_0000, 32'h7F80_0000},
        {8'd5, 32'h8000_0000, 32'hFF80_0000},
        {8'd5, 32'h0000_0001, 32'h7F80_0000},
        {8'd5, 32'h807F_FFFF, 32'hFF80_0000},
        {8'd6, 32'h7F80_0000, 32'h0000_0000},
        {8'd6, 32'hFF80_0000, 32'h8000_0000},
        {8'd7, 32'h7FC0_0001, 32'h7FC0_0000},
        {8'd7, 32'hFF80_0001, 32'h7FC0_0000},
        {8'd8, 32'h7F00_0000, 32'h0000_0000},
        {8'd8, 32'h7F7F_FFFF, 32'h0000_0000},
        {8'd8, 32'h7EC0_0000, 32'h0000_0000},
        {8'd8, 32'hFEFF_FFFF, 32'h8000_0000}
    };

    function automatic string req_name(input logic [7:0] n);
        case (n)
            8'd3:    return "R3";
            8'd5:    return "R5";
            8'd6:    return "R6";
            8'd7:    return "R7";
            8'd8:    return "R8";
            default: return "R4";
        endcase
    endfunction

    function automatic real pow2(input int k);
        real r;
        r = 1.0;
        if (k >= 0) begin
            for (int i = 0; i < k; i++) r = r * 2.0;
        end else begin
            for (int i = 0; i < -k; i++) r = r * 0.5;
        end
        return r;
    endfunction

    function automatic real f2r(input logic [31:0] b);
        real m;
        m = (1.0 + real'(b[22:0]) / 8388608.0) * pow2(int'(b[30:23]) - 127);
        return b[31] ? -m : m;
    endfunction

    task automatic tally(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] d, input logic [31:0] e,
                        input bit exact, input string req);
        in_valid = 1'b1;
        in_data  = d;
        q_in[n_sent]    = d;
        q_exp[n_sent]   = e;
        q_exact[n_sent] = exact;
        q_cyc[n_sent]   = cyc;
        q_req[n_sent]   = req;
        n_sent++;
        @(negedge clk);
    endtask

    // Normal operand with e in 1..252: exact when fraction is zero (R3), else ulp-checked (R4)
    task automatic send_auto(input logic [31:0] d);
        if (d[22:0] == 23'd0) begin
            send(d, {d[31], 8'(8'd254 - d[30:23]), 23'd0}, 1'b1, "R3");
        end else begin
            send(d, 32'd0, 1'b0, "R4");
        end
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic check_approx(input logic [31:0] din, input logic [31:0] dout, input string req);
        int  e, eo;
        real err, ulp, ref_v;
        bit  ok;
        e     = int'(din[30:23]);
        eo    = int'(dout[30:23]);
        ref_v = 1.0 / f2r(din);
        ok    = (dout[31] == din[31]) && (eo == 253 - e || eo == 254 - e) && eo != 0;
        err   = f2r(dout) - ref_v;
        if (err < 0.0) err = -err;
        ulp   = pow2(eo - 150);
        if (ok && err > ulp) ok = 1'b0;
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s value for %h: actual %h (%g) expected %g within 1 ulp",
                     req, din, dout, f2r(dout), ref_v);
        end
    endtask

    // Result monitor: arrival cycle and value (R1 plus the item's own requirement)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (n_recv >= n_sent) begin
                tally(1'b0, "R1", "unexpected out_valid", out_data, 32'd0);
            end else begin
                tally(cyc - q_cyc[n_recv] == 8, "R1", "latency",
                      32'(cyc - q_cyc[n_recv]), 32'd8);
                if (q_exact[n_recv]) begin
                    tally(out_data === q_exp[n_recv], q_req[n_recv], "result",
                          out_data, q_exp[n_recv]);
                end else begin
                    check_approx(q_in[n_recv], out_data, q_req[n_recv]);
                end
                n_recv++;
            end
        end
    end

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] rng;
        rng      = 32'h1234_5678;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = 32'd0;
        repeat (3) @(negedge clk);
        // R2: quiet while reset is held
        tally(out_valid === 1'b0, "R2", "out_valid during reset", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table, streamed back to back
        for (int k = 0; k < NVEC; k++) begin
            send(VEC[k][63:32], VEC[k][31:0], 1'b1, req_name(VEC[k][71:64]));
        end
        idle(12);

        // R4: named non-power-of-two operands
        send_auto(32'h4040_0000);
        send_auto(32'h3FC0_0000);
        send_auto(32'h3FFF_FFFF);
        send_auto(32'h3F80_0001);
        send_auto(32'h4120_0000);
        send_auto(32'hC2F6_E979);
        send_auto(32'h0080_0001);
        send_auto(32'h7E7F_FFFF);

        // R4: both ends of every table segment
        for (int i = 0; i < 128; i++) begin
            send_auto({1'b0, 8'd127, i[6:0], 16'h0000});
            send_auto({1'b1, 8'd130, i[6:0], 16'hFFFF});
        end

        // R4: pseudo-random operands
        for (int i = 0; i < 300; i++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            send_auto({rng[31], 8'd60 + {1'b0, rng[30:24]}, rng[22:0] | 23'd1});
        end
        idle(12);

        // R1: gaps in the input stream
        send_auto(32'h4040_0000);
        send_auto(32'h4080_0000);
        idle(3);
        send_auto(32'h40A0_0000);
        idle(1);
        send_auto(32'h40C0_0000);
        send_auto(32'h40E0_0000);
        idle(12);
        tally(n_recv == n_sent, "R1", "results returned", 32'(n_recv), 32'(n_sent));

        // R2: operands in flight are dropped by reset
        in_valid = 1'b1;
        in_data  = 32'h3F80_0000;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            tally(out_valid === 1'b0, "R2", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            tally(out_valid === 1'b0, "R2", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        end

        // R1: unit resumes after reset
        send_auto(32'h4040_0000);
        idle(12);
        tally(n_recv == n_sent, "R1", "results after reset", 32'(n_recv), 32'(n_sent));
        finish_up();
    end

endmodule